// File: doc/BRIEF.md
# Flash Region Access Guard

This block stands between the requesters of a program flash array and the array itself. For every request it decides whether the access may go ahead. Requests come from the CPU's table instructions (internal) or from an external programmer. The flash byte address is mapped onto five protection regions: a 2 KB boot region at the bottom, then one region that runs up to the first 8 KB boundary, then one region for each further 8 KB block. Each region has three active-low protection bits: an external-access lock, a table-write lock and a cross-region table-read lock.

A table read of a region whose cross-region lock is 0 goes ahead only when the instruction doing the read sits in the same region. A read from anywhere else is not faulted. The block flags it so that the read data is replaced by all zeros. The same block also gates data EEPROM accesses with two global active-low bits, one for external access and one for writes. The CPU can always read the EEPROM.

The decision is registered. It appears one clock after the request strobe, together with the region index. A denied write sets a sticky violation flag, which only reset clears.

Top module: `flashGuard`

## Requirements
- R1: A flash address is decoded to a region index in this way. 0x0000–0x07FF gives 0, 0x0800–0x1FFF gives 1, 0x2000–0x3FFF gives 2, 0x4000–0x5FFF gives 3 and 0x6000–0x7FFF gives 4. The index 7 means "no flash region". It is shown for EEPROM requests, for out-of-range addresses and for idle cycles.
- R2: `grant`, `zeroData` and `regionIdx` are registered. They show the decision for a request one clock after the cycle in which `reqValid` was 1. After a cycle with `reqValid`=0 they read 0, 0 and 7, and they read the same after reset.
- R3: Internal flash accesses (`reqExt`=0) ignore the external-access lock bits (`cpBits`).
- R4: An external flash read or write of region n is granted only if `cpBits[n]`=1.
- R5: An internal flash write of region n is granted only if `wrtBits[n]`=1.
- R6: An internal flash read of region n is granted if `ebtrBits[n]`=1, or if `pcAddr` decodes to region n. Otherwise `grant`=0 and `zeroData`=1.
- R7: A flash address at or above FLASH_KB*1024 (0x8000 by default) is denied, with `grant`=0, `zeroData`=0 and `regionIdx`=7.
- R8: EEPROM requests (`reqSpace`=1) are handled as follows. An internal read is always granted. An internal write needs `eepWrt`=1. An external read needs `eepCp`=1. An external write needs both.
- R9: Any denied write, to flash or to EEPROM, sets `violation`, which stays 1 until reset. Denied reads leave it unchanged.
- R10: `grant` and `zeroData` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request strobe for this cycle |
| reqSpace | input | 1 | 0 = program flash, 1 = data EEPROM |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqExt | input | 1 | 1 = external programmer, 0 = CPU table instruction |
| reqAddr | input | ADDR_W | Target byte address |
| pcAddr | input | ADDR_W | Address of the instruction that issues an internal request |
| cpBits | input | 5 | External-access lock per region, active low |
| wrtBits | input | 5 | Table-write lock per region, active low |
| ebtrBits | input | 5 | Cross-region table-read lock per region, active low |
| eepCp | input | 1 | EEPROM external-access lock, active low |
| eepWrt | input | 1 | EEPROM write lock, active low |
| grant | output | 1 | Access allowed (registered) |
| zeroData | output | 1 | Read completes with zero data (registered) |
| regionIdx | output | 3 | Decoded region of the target, 7 for none (registered) |
| violation | output | 1 | Sticky denied-write flag |

## Verification
The assertions check the following on every clock:
- `grant` and `zeroData` are never 1 together.
- The violation flag stays set once it is set.
- Idle cycles and out-of-range addresses give the neutral outputs.
- An internal EEPROM read is always granted.
- An internal flash read of a region whose cross-region lock is open is granted whatever its external-access lock holds.

Only the bench's scenarios can show the rest: the exact region boundaries, the same-region exemption for locked table reads, each lock bit denying only its own kind of access, and the violation flag being cleared by reset but not set by denied reads.

// File: rtl/flashGuardPkg.sv
package flashGuardPkg;
  localparam int REGION_CNT = 5;
  typedef logic [2:0] regionT;
  localparam regionT NO_REGION = 3'd7;

  typedef struct packed {
    logic capture;
    logic idle;
    logic markViol;
  } ctrlStrobeT;
endpackage

// File: rtl/fgRegionDecode.sv
module fgRegionDecode
  import flashGuardPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int FLASH_KB = 32,
  parameter int BOOT_BYTES = 2048,
  parameter int BLOCK_BYTES = 8192
) (
  input  logic [ADDR_W-1:0] addr,
  output regionT            region,
  output logic              inRange
);
  localparam int LIMIT = FLASH_KB * 1024;
  localparam int SHIFT = $clog2(BLOCK_BYTES);

  logic [31:0] wideAddr;
  logic [31:0] blockNum;

  always_comb begin
    wideAddr = 32'(addr);
    blockNum = wideAddr >> SHIFT;
    inRange  = wideAddr < 32'(LIMIT);
    if (!inRange)
      region = NO_REGION;
    else if (wideAddr < 32'(BOOT_BYTES))
      region = 3'd0;
    else if (blockNum == 32'd0)
      region = 3'd1;
    else
      region = regionT'(blockNum + 32'd1);
  end
endmodule

// File: rtl/fgControl.sv
module fgControl
  import flashGuardPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic       allowNow,
  output ctrlStrobeT strobe
);
  always_comb begin
    strobe.capture  = reqValid;
    strobe.idle     = !reqValid;
    strobe.markViol = reqValid && reqWrite && !allowNow;
  end

  // R9: only a write can raise the violation strobe
  a_r9_viol_write_only: assert property (@(posedge clk) disable iff (!rstN)
    strobe.markViol |-> reqWrite);
endmodule

// File: rtl/fgDatapath.sv
module fgDatapath
  import flashGuardPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int FLASH_KB = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strobe,
  input  logic              reqValid,
  input  logic              reqSpace,
  input  logic              reqWrite,
  input  logic              reqExt,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ADDR_W-1:0] pcAddr,
  input  logic [REGION_CNT-1:0] cpBits,
  input  logic [REGION_CNT-1:0] wrtBits,
  input  logic [REGION_CNT-1:0] ebtrBits,
  input  logic              eepCp,
  input  logic              eepWrt,
  output logic              allowNow,
  output logic              grant,
  output logic              zeroData,
  output regionT            regionIdx,
  output logic              violation
);
  localparam int PAD = 8 - REGION_CNT;

  regionT tgtRegion, pcRegion, shownRegion;
  logic   tgtIn, pcIn, zeroNow;
  logic [7:0] cpPad, wrtPad, ebtrPad;

  for (genvar g = 0; g < 2; g++) begin : g_dec
    if (g == 0) begin : g_tgt
      fgRegionDecode #(.ADDR_W(ADDR_W), .FLASH_KB(FLASH_KB)) u_dec (
        .addr(reqAddr), .region(tgtRegion), .inRange(tgtIn));
    end else begin : g_pc
      fgRegionDecode #(.ADDR_W(ADDR_W), .FLASH_KB(FLASH_KB)) u_dec (
        .addr(pcAddr), .region(pcRegion), .inRange(pcIn));
    end
  end

  assign cpPad   = {{PAD{1'b0}}, cpBits};
  assign wrtPad  = {{PAD{1'b0}}, wrtBits};
  assign ebtrPad = {{PAD{1'b0}}, ebtrBits};

  always_comb begin
    allowNow    = 1'b0;
    zeroNow     = 1'b0;
    shownRegion = NO_REGION;
    if (!reqSpace) begin
      if (tgtIn) begin
        shownRegion = tgtRegion;
        if (reqExt)
          allowNow = cpPad[tgtRegion];
        else if (reqWrite)
          allowNow = wrtPad[tgtRegion];
        else if (ebtrPad[tgtRegion] || (pcIn && pcRegion == tgtRegion))
          allowNow = 1'b1;
        else
          zeroNow = 1'b1;
      end
    end else begin
      if (reqExt)
        allowNow = eepCp && (!reqWrite || eepWrt);
      else
        allowNow = !reqWrite || eepWrt;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grant     <= 1'b0;
      zeroData  <= 1'b0;
      regionIdx <= NO_REGION;
    end else if (strobe.capture) begin
      grant     <= allowNow;
      zeroData  <= zeroNow;
      regionIdx <= shownRegion;
    end else if (strobe.idle) begin
      grant     <= 1'b0;
      zeroData  <= 1'b0;
      regionIdx <= NO_REGION;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      violation <= 1'b0;
    else if (strobe.markViol)
      violation <= 1'b1;
  end

  // R10: grant and zero substitution are exclusive
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(grant && zeroData));
  // R9: violation is sticky
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rstN)
    violation |=> violation);
  // R2: idle cycle gives neutral outputs
  a_r2_idle: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!grant && !zeroData && regionIdx == NO_REGION));
  // R7: out-of-range flash denied
  a_r7_range: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqSpace && !tgtIn) |=> (!grant && !zeroData && regionIdx == NO_REGION));
  // R8: CPU EEPROM read always allowed
  a_r8_eep_read: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqSpace && !reqWrite && !reqExt) |=> grant);
  // R3: internal read with open cross-region lock granted regardless of cpBits
  a_r3_cp_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqSpace && !reqExt && !reqWrite && tgtIn && ebtrPad[tgtRegion]) |=> grant);
endmodule

// File: rtl/flashGuard.sv
module flashGuard
  import flashGuardPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int FLASH_KB = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqSpace,
  input  logic              reqWrite,
  input  logic              reqExt,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ADDR_W-1:0] pcAddr,
  input  logic [4:0]        cpBits,
  input  logic [4:0]        wrtBits,
  input  logic [4:0]        ebtrBits,
  input  logic              eepCp,
  input  logic              eepWrt,
  output logic              grant,
  output logic              zeroData,
  output logic [2:0]        regionIdx,
  output logic              violation
);
  ctrlStrobeT strobe;
  logic       allowNow;

  fgControl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .allowNow(allowNow), .strobe(strobe));

  fgDatapath #(.ADDR_W(ADDR_W), .FLASH_KB(FLASH_KB)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqValid(reqValid),
    .reqSpace(reqSpace), .reqWrite(reqWrite), .reqExt(reqExt),
    .reqAddr(reqAddr), .pcAddr(pcAddr), .cpBits(cpBits), .wrtBits(wrtBits),
    .ebtrBits(ebtrBits), .eepCp(eepCp), .eepWrt(eepWrt),
    .allowNow(allowNow), .grant(grant), .zeroData(zeroData),
    .regionIdx(regionIdx), .violation(violation));
endmodule

// File: tb/sim_flashGuard.sv
module sim_flashGuard;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqSpace = 1'b0, reqWrite = 1'b0, reqExt = 1'b0;
  logic [15:0] reqAddr = '0, pcAddr = '0;
  logic [4:0] cpBits = 5'b11110, wrtBits = 5'b11101, ebtrBits = 5'b11011;
  logic eepCp = 1'b1, eepWrt = 1'b1;
  logic grant, zeroData, violation;
  logic [2:0] regionIdx;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  flashGuard u0 (.*);

  // {space, write, ext, addr, pc, expGrant, expZero, expRegion}
  localparam logic [39:0] VEC [16] = '{
    {3'b000, 16'h0100, 16'h0200, 1'b1, 1'b0, 3'd0}, // R3 cp0 ignored internally
    {3'b001, 16'h0100, 16'h0000, 1'b0, 1'b0, 3'd0}, // R4 ext read locked
    {3'b001, 16'h0900, 16'h0000, 1'b1, 1'b0, 3'd1}, // R4 ext read open
    {3'b010, 16'h0900, 16'h0000, 1'b0, 1'b0, 3'd1}, // R5 write locked
    {3'b010, 16'h2100, 16'h0000, 1'b1, 1'b0, 3'd2}, // R5 write open
    {3'b000, 16'h2100, 16'h0400, 1'b0, 1'b1, 3'd2}, // R6 cross-region zeros
    {3'b000, 16'h3FFE, 16'h2004, 1'b1, 1'b0, 3'd2}, // R6 same region
    {3'b000, 16'h4000, 16'h0000, 1'b1, 1'b0, 3'd3}, // R1 region 3
    {3'b011, 16'h7FFF, 16'h0000, 1'b1, 1'b0, 3'd4}, // R1 region 4
    {3'b001, 16'h8000, 16'h0000, 1'b0, 1'b0, 3'd7}, // R7 out of range
    {3'b000, 16'h07FF, 16'h0800, 1'b1, 1'b0, 3'd0}, // R1 boot top
    {3'b000, 16'h0800, 16'h07FF, 1'b1, 1'b0, 3'd1}, // R1 region 1 base
    {3'b110, 16'h0010, 16'h0000, 1'b1, 1'b0, 3'd7}, // R8 eep internal write
    {3'b101, 16'h0010, 16'h0000, 1'b1, 1'b0, 3'd7}, // R8 eep ext read
    {3'b011, 16'h0000, 16'h0000, 1'b0, 1'b0, 3'd0}, // R4 ext write locked
    {3'b000, 16'h6000, 16'h2000, 1'b1, 1'b0, 3'd4}  // R6 open lock
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doReq(input logic s, input logic w, input logic e,
                       input logic [15:0] a, input logic [15:0] p);
    @(negedge clk);
    reqSpace = s; reqWrite = w; reqExt = e; reqAddr = a; pcAddr = p;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  function automatic logic [7:0] outs();
    return {3'b0, grant, zeroData, regionIdx};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk("R2 reset outputs", {4'b0, grant, zeroData, regionIdx[1:0]}, 8'b0000_0011);
    chk("R9 reset violation", {7'b0, violation}, 8'd0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 16; i++) begin
      doReq(VEC[i][39], VEC[i][38], VEC[i][37], VEC[i][36:21], VEC[i][20:5]);
      chk($sformatf("R1/R3-R8 vector %0d", i), outs(), {3'b0, VEC[i][4:0]});
      chk($sformatf("R10 vector %0d", i), {7'b0, grant & zeroData}, 8'd0);
    end

    @(negedge clk);
    chk("R2 idle after request", outs(), {3'b0, 5'b00111});
    chk("R9 violation set by denied write", {7'b0, violation}, 8'd1);

    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    chk("R9 cleared by reset", {7'b0, violation}, 8'd0);

    doReq(1'b0, 1'b0, 1'b1, 16'h0100, 16'h0000);
    chk("R4 ext read denied", outs(), {3'b0, 5'b00000});
    chk("R9 denied read no violation", {7'b0, violation}, 8'd0);

    eepCp = 1'b0; eepWrt = 1'b0;
    doReq(1'b1, 1'b0, 1'b0, 16'h0020, 16'h0000);
    chk("R8 eep int read always", outs(), {3'b0, 5'b10111});
    doReq(1'b1, 1'b0, 1'b1, 16'h0020, 16'h0000);
    chk("R8 eep ext read locked", outs(), {3'b0, 5'b00111});
    chk("R9 still clear", {7'b0, violation}, 8'd0);
    doReq(1'b1, 1'b1, 1'b0, 16'h0020, 16'h0000);
    chk("R8 eep int write locked", outs(), {3'b0, 5'b00111});
    chk("R9 eep denied write sets", {7'b0, violation}, 8'd1);
    eepCp = 1'b1;
    doReq(1'b1, 1'b1, 1'b1, 16'h0020, 16'h0000);
    chk("R8 eep ext write needs both", outs(), {3'b0, 5'b00111});

    ebtrBits = 5'b00000;
    doReq(1'b0, 1'b0, 1'b0, 16'h0010, 16'h0700);
    chk("R6 boot read from boot", outs(), {3'b0, 5'b10000});
    doReq(1'b0, 1'b0, 1'b0, 16'h0010, 16'h0800);
    chk("R6 boot read from region1", outs(), {3'b0, 5'b01000});
    doReq(1'b0, 1'b0, 1'b0, 16'h5000, 16'h4FF0);
    chk("R6 region3 read same region", outs(), {3'b0, 5'b10011});

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule